// File: doc/BRIEF.md
# SMBus Register-Access Slave

This block lets an SMBus master reach a small on-chip register bank, such as the registers of a monitoring block. It filters the raw SCL and SDA lines and finds START, repeated START and STOP conditions. It answers only its own 7-bit device address. The top six bits of that address are fixed by a parameter. The lowest bit comes from a strap input, so two copies can share one bus. The slave pulls SDA low through an open-drain enable. It does not drive the line high.

Four transactions are served. Write byte stores one byte into a register. Read byte fetches one register, using a repeated START between the register byte and the read address. Send byte only moves an internal register pointer. Receive byte returns the register under that pointer, and does so again on every repeat. The pointer persists between transactions.

A register write reaches the bank only on the STOP that closes a fully valid write byte. A bad device address, an unknown or reserved register, or an unsupported sequence gets no acknowledge. After that the slave stays silent until the next START.

Top module: `smb_regport`

## Requirements
- R1: After reset, `sda_oe` is 0, `reg_wr_en` is 0 and `reg_addr` (the pointer) is 0x00.
- R2: The slave acknowledges an address byte only when its upper seven bits equal `{ADDR_HI, a0_strap}`. With the default `ADDR_HI` of 6'b010110, this is 7'h2C when the strap is 0 and 7'h2D when it is 1. Every other address gets a NACK.
- R3: The general call address 7'h00 is never acknowledged, with either R or W.
- R4: A write byte (START, address+W, register, data, STOP) gives exactly one `reg_wr_en` pulse, in the cycles after the STOP is seen. During that pulse `reg_addr` is the register and `reg_wdata` is the data.
- R5: A read byte (START, address+W, register, repeated START, address+R, data, master NACK, STOP) returns the byte presented on `reg_rdata` for that register, MSB first.
- R6: A send byte (START, address+W, register, STOP) loads the pointer and causes no write. Each later receive byte (START, address+R, data, NACK, STOP) returns the register at the pointer, including on repeats.
- R7: A valid register byte moves the pointer to that register in a write byte as well.
- R8: A register byte is valid only if it is below NUM_REGS (32) and is not set in RSVD_MASK (by default registers 0x0A and 0x0F are reserved). An invalid register byte is NACKed, nothing is written and the pointer keeps its value.
- R9: A write byte is dropped with no `reg_wr_en` when any of these happens: a START arrives before the STOP, a STOP arrives in the middle of the data byte, or a second data byte follows. A second data byte is also NACKed.
- R10: When the address after the repeated START of a read byte carries W, it is NACKed.
- R11: After a NACK the slave acknowledges nothing and drives nothing until the next START.
- R12: `sda_oe` only becomes active while the filtered SCL is low, and never while the master holds SCL high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a0_strap | input | 1 | Strap level used as the device address LSB |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr | output | 8 | Register pointer, used for reads and for the write strobe |
| reg_rdata | input | 8 | Read data of the register at `reg_addr` |
| reg_wr_en | output | 1 | One-cycle write strobe to the bank |
| reg_wdata | output | 8 | Data that goes with `reg_wr_en` |

## Verification
Bound assertions watch four things on every cycle. A write strobe lasts one cycle and follows a detected STOP. The strobe never targets a reserved or out-of-range register. The general call never reaches the acknowledge state. SDA is claimed only with SCL low, and only in acknowledge or read-data states.

Some behaviour can only be shown by the bench's bus scenarios:
- the full address sweep;
- pointer persistence across send and receive byte;
- the readback values;
- the aborted-write cases, and silence after a rejection.

Those depend on whole transactions rather than on a single cycle.

// File: rtl/smb_regport_pkg.sv
// Package: shared types and constants for the SMBus register slave.
// Assumes bytes of 8 bits and bit 0 of the address byte as the direction flag.
package smb_regport_pkg;

    localparam int BYTE_W = 8;

    localparam logic DIR_WRITE = 1'b0;
    localparam logic DIR_READ  = 1'b1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_END,
        ST_RDATA,
        ST_RACK
    } smb_state_e;

endpackage

// File: rtl/smb_line_filter.sv
// Line filter: brings one asynchronous bus line into the clock domain and drops
// glitches. The output follows the input only after FILT_LEN equal samples.
// Assumes SYNC_STAGES >= 2 and FILT_LEN >= 2. Resets to the idle bus level (1).
module smb_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;

    // Synchronize the line, keep a sample history, and switch on unanimity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q   <= '1;
            hist_q   <= '1;
            line_out <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q) begin
                line_out <= 1'b1;
            end else if (~|hist_q) begin
                line_out <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/smb_bus_events.sv
// Bus event detector: turns the filtered SCL/SDA levels into single-cycle
// events: SCL rise, SCL fall, START (SDA falls with SCL high) and STOP
// (SDA rises with SCL high). Assumes filtered inputs that do not glitch.
module smb_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    logic scl_q;
    logic sda_q;

    // Keep the previous filtered levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Decode edges and bus conditions from current versus previous levels.
    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        bus_start = scl_f & scl_q & sda_q & ~sda_f;
        bus_stop  = scl_f & scl_q & ~sda_q & sda_f;
    end

endmodule

// File: rtl/smb_reg_decode.sv
// Register validity decoder: a register byte is accepted when it lies below
// NUM_REGS and its bit in RSVD_MASK is clear. Assumes NUM_REGS is a power of two.
module smb_reg_decode #(
    parameter int                  NUM_REGS  = 32,
    parameter logic [NUM_REGS-1:0] RSVD_MASK = '0
) (
    input  logic [7:0] reg_byte,
    output logic       reg_ok
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic in_range;

    // Combine the range test with the reserved-register mask.
    always_comb begin
        in_range = ({24'd0, reg_byte} < NUM_REGS);
        reg_ok   = in_range && !RSVD_MASK[reg_byte[IDX_W-1:0]];
    end

endmodule

// File: rtl/smb_regport.sv
// SMBus register slave top. Filters the bus lines, tracks the transaction
// with a bit-level state machine, acknowledges its own address and valid
// registers, serves reads from reg_rdata at the pointer, and strobes a staged
// write on the STOP that ends a valid write byte. Assumes the bank answers
// reg_rdata combinationally from reg_addr. No clock stretching.
module smb_regport
    import smb_regport_pkg::*;
#(
    parameter logic [5:0]          ADDR_HI     = 6'b010110,
    parameter int                  NUM_REGS    = 32,
    parameter logic [NUM_REGS-1:0] RSVD_MASK   = 32'h0000_8400,
    parameter int                  SYNC_STAGES = 2,
    parameter int                  FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       a0_strap,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    output logic [7:0] reg_addr,
    input  logic [7:0] reg_rdata,
    output logic       reg_wr_en,
    output logic [7:0] reg_wdata
);

    localparam int                CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [2:0]        IDX_TOP  = 3'd7;

    logic [1:0] raw_lines;
    logic [1:0] flt_lines;
    logic       scl_flt;
    logic       sda_flt;

    logic ev_rise;
    logic ev_fall;
    logic ev_start;
    logic ev_stop;

    smb_state_e       st;
    logic [CNT_W-1:0] bitcnt;
    logic [7:0]       shreg;
    logic [7:0]       txbyte;
    logic [7:0]       ptr;
    logic [7:0]       stage;
    logic             oe_q;
    logic             dir_q;
    logic             rs_flag;
    logic             commit_pend;
    logic             wr_pulse;
    logic             addr_ok;
    logic             reg_ok;

    assign raw_lines = {sda_in, scl_in};

    // One filter per bus line: index 0 is SCL, index 1 is SDA.
    for (genvar gi = 0; gi < 2; gi++) begin : g_line
        smb_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (raw_lines[gi]),
            .line_out(flt_lines[gi])
        );
    end

    assign scl_flt = flt_lines[0];
    assign sda_flt = flt_lines[1];

    smb_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_flt),
        .sda_f    (sda_flt),
        .scl_rise (ev_rise),
        .scl_fall (ev_fall),
        .bus_start(ev_start),
        .bus_stop (ev_stop)
    );

    smb_reg_decode #(
        .NUM_REGS (NUM_REGS),
        .RSVD_MASK(RSVD_MASK)
    ) u_decode (
        .reg_byte(shreg),
        .reg_ok  (reg_ok)
    );

    // Address match: fixed upper bits plus strap, and no write after a repeated START.
    always_comb begin
        addr_ok = (shreg[7:1] == {ADDR_HI, a0_strap}) &&
                  !(rs_flag && (shreg[0] == DIR_WRITE));
    end

    // Transaction state machine: STOP, then START, then SCL edges, by priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            bitcnt      <= '0;
            shreg       <= '0;
            txbyte      <= '0;
            ptr         <= '0;
            stage       <= '0;
            oe_q        <= 1'b0;
            dir_q       <= DIR_WRITE;
            rs_flag     <= 1'b0;
            commit_pend <= 1'b0;
            wr_pulse    <= 1'b0;
        end else begin
            wr_pulse <= 1'b0;
            if (ev_stop) begin
                if (st == ST_END && commit_pend && bitcnt <= CNT_ONE) begin
                    wr_pulse <= 1'b1;
                end
                st          <= ST_IDLE;
                oe_q        <= 1'b0;
                commit_pend <= 1'b0;
                rs_flag     <= 1'b0;
            end else if (ev_start) begin
                oe_q        <= 1'b0;
                bitcnt      <= '0;
                commit_pend <= 1'b0;
                if (st == ST_IDLE || st == ST_END) begin
                    st      <= ST_ADDR;
                    rs_flag <= 1'b0;
                end else if (st == ST_WDATA && bitcnt <= CNT_ONE) begin
                    st      <= ST_ADDR;
                    rs_flag <= 1'b1;
                end else begin
                    st      <= ST_IDLE;
                    rs_flag <= 1'b0;
                end
            end else if (ev_rise) begin
                case (st)
                    ST_ADDR, ST_REG, ST_WDATA: begin
                        shreg  <= {shreg[6:0], sda_flt};
                        bitcnt <= bitcnt + CNT_ONE;
                    end
                    ST_RDATA: begin
                        bitcnt <= bitcnt + CNT_ONE;
                    end
                    ST_RACK: begin
                        if (sda_flt) begin
                            st     <= ST_END;
                            bitcnt <= '0;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                    ST_END: begin
                        if (bitcnt >= CNT_ONE) begin
                            st          <= ST_IDLE;
                            commit_pend <= 1'b0;
                        end else begin
                            bitcnt <= bitcnt + CNT_ONE;
                        end
                    end
                    default: begin
                    end
                endcase
            end else if (ev_fall) begin
                case (st)
                    ST_ADDR: begin
                        if (bitcnt == CNT_FULL) begin
                            if (addr_ok) begin
                                st    <= ST_ADDR_ACK;
                                oe_q  <= 1'b1;
                                dir_q <= shreg[0];
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        bitcnt <= '0;
                        if (dir_q == DIR_READ) begin
                            st     <= ST_RDATA;
                            txbyte <= reg_rdata;
                            oe_q   <= ~reg_rdata[7];
                        end else begin
                            st   <= ST_REG;
                            oe_q <= 1'b0;
                        end
                    end
                    ST_REG: begin
                        if (bitcnt == CNT_FULL) begin
                            if (reg_ok) begin
                                ptr  <= shreg;
                                oe_q <= 1'b1;
                                st   <= ST_REG_ACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_REG_ACK: begin
                        oe_q   <= 1'b0;
                        bitcnt <= '0;
                        st     <= ST_WDATA;
                    end
                    ST_WDATA: begin
                        if (bitcnt == CNT_FULL) begin
                            stage <= shreg;
                            oe_q  <= 1'b1;
                            st    <= ST_WDATA_ACK;
                        end
                    end
                    ST_WDATA_ACK: begin
                        oe_q        <= 1'b0;
                        bitcnt      <= '0;
                        commit_pend <= 1'b1;
                        st          <= ST_END;
                    end
                    ST_RDATA: begin
                        if (bitcnt == CNT_FULL) begin
                            oe_q <= 1'b0;
                            st   <= ST_RACK;
                        end else begin
                            oe_q <= ~txbyte[IDX_TOP - bitcnt[2:0]];
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign sda_oe    = oe_q;
    assign reg_addr  = ptr;
    assign reg_wr_en = wr_pulse;
    assign reg_wdata = stage;

endmodule

// File: rtl/smb_regport_chk.sv
// Checker for smb_regport: cycle-level properties on the write strobe, the
// SDA enable and the acknowledge decision. Attached by bind below.
module smb_regport_chk
    import smb_regport_pkg::*;
#(
    parameter int                  NUM_REGS  = 32,
    parameter logic [NUM_REGS-1:0] RSVD_MASK = '0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       reg_wr_en,
    input logic [7:0] reg_addr,
    input logic       scl_flt,
    input logic       ev_stop,
    input smb_state_e st,
    input logic [7:0] shreg
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    // R4
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R4
    wr_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> $past(ev_stop));

    // R8
    wr_valid_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (({24'd0, reg_addr} < NUM_REGS) && !RSVD_MASK[reg_addr[IDX_W-1:0]]));

    // R3
    no_general_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR_ACK) |-> (shreg[7:1] != 7'd0));

    // R12
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_flt);

    // R11
    oe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (st == ST_ADDR_ACK || st == ST_REG_ACK ||
                    st == ST_WDATA_ACK || st == ST_RDATA));

endmodule

bind smb_regport smb_regport_chk #(
    .NUM_REGS (NUM_REGS),
    .RSVD_MASK(RSVD_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .reg_wr_en(reg_wr_en),
    .reg_addr (reg_addr),
    .scl_flt  (scl_flt),
    .ev_stop  (ev_stop),
    .st       (st),
    .shreg    (shreg)
);

// File: tb/smb_regport_test.sv
// Bench for smb_regport: a bit-banged SMBus master, a behavioural register
// bank, and sweeps over addresses and registers with expected values from
// the requirements.
module smb_regport_test;

    localparam int H  = 8;
    localparam int WD = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a0 = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       reg_wr_en;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    logic [7:0] bank  [0:255];
    logic [7:0] model [0:255];

    int  total = 0;
    int  bad = 0;
    int  wr_count = 0;
    int  exp_wr = 0;
    int  hi_changes = 0;
    bit  done = 1'b0;
    logic prev_oe = 1'b0;

    always #2 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = bank[reg_addr];

    smb_regport uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .a0_strap (a0),
        .scl_in   (scl_m),
        .sda_in   (sda_line),
        .sda_oe   (sda_oe),
        .reg_addr (reg_addr),
        .reg_rdata(reg_rdata),
        .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata)
    );

    // Register bank model at the port: store strobed writes and count them.
    always @(posedge clk) begin
        if (reg_wr_en) begin
            bank[reg_addr] <= reg_wdata;
            wr_count <= wr_count + 1;
        end
    end

    // R12: count SDA enable changes while the master holds SCL high.
    always @(negedge clk) begin
        if (rst_n && scl_m && (sda_oe !== prev_oe)) hi_changes++;
        prev_oe <= sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    function automatic bit reg_valid(input int r);
        return (r < 32) && (r != 10) && (r != 15);
    endfunction

    function automatic logic [7:0] dev_byte(input logic rw);
        return {6'b010110, a0, rw};
    endfunction

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; half();
        sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b1; half();
        half();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; half();
        scl_m = 1'b1; half();
        scl_m = 1'b0; half();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        b = sda_line;
        scl_m = 1'b0; half();
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(nack);
    endtask

    task automatic do_write(input logic [7:0] r, input logic [7:0] d,
                            output logic ka, output logic kr, output logic kd);
        bus_start();
        put_byte(dev_byte(1'b0), ka);
        put_byte(r, kr);
        kd = 1'b0;
        if (kr) put_byte(d, kd);
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] r, output logic kr,
                           output logic ka2, output logic [7:0] v);
        logic ka;
        bus_start();
        put_byte(dev_byte(1'b0), ka);
        put_byte(r, kr);
        ka2 = 1'b0;
        v = 8'h00;
        if (kr) begin
            bus_rstart();
            put_byte(dev_byte(1'b1), ka2);
            if (ka2) get_byte(1'b1, v);
        end
        bus_stop();
    endtask

    task automatic do_send(input logic [7:0] r, output logic kr);
        logic ka;
        bus_start();
        put_byte(dev_byte(1'b0), ka);
        put_byte(r, kr);
        bus_stop();
    endtask

    task automatic do_recv(output logic ka, output logic [7:0] v);
        bus_start();
        put_byte(dev_byte(1'b1), ka);
        v = 8'h00;
        if (ka) get_byte(1'b1, v);
        bus_stop();
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Watchdog: a hung run counts as one failed check and still reports.
    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
            summary();
            $finish;
        end
    end

    // Main scenario sequence.
    initial begin
        logic ka, kr, kd, k2;
        logic [7:0] v;
        logic [7:0] d;
        int wr_before;

        for (int i = 0; i < 256; i++) begin
            bank[i]  = 8'(i) ^ 8'hA5;
            model[i] = 8'(i) ^ 8'hA5;
        end

        repeat (10) @(negedge clk);
        // R1: reset state
        chk(sda_oe == 1'b0, "R1 sda_oe", int'(sda_oe), 0);
        chk(reg_wr_en == 1'b0, "R1 reg_wr_en", int'(reg_wr_en), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(reg_addr == 8'h00, "R1 pointer", int'(reg_addr), 0);

        // R2 / R3: sweep every 7-bit address with the strap low
        for (int a = 0; a < 128; a++) begin
            bus_start();
            put_byte({7'(a), 1'b0}, ka);
            bus_stop();
            if (a == 0) chk(ka == 1'b0, "R3 general call", int'(ka), 0);
            else chk(ka == (a == 7'h2C), "R2 address sweep", int'(ka), int'(a == 7'h2C));
        end
        // R3: general call with read direction
        bus_start();
        put_byte(8'h01, ka);
        bus_stop();
        chk(ka == 1'b0, "R3 general call read", int'(ka), 0);
        // R2: strap high moves the address
        a0 = 1'b1;
        bus_start(); put_byte(8'h58, ka); bus_stop();
        chk(ka == 1'b0, "R2 strap high old addr", int'(ka), 0);
        bus_start(); put_byte(8'h5A, ka); bus_stop();
        chk(ka == 1'b1, "R2 strap high new addr", int'(ka), 1);
        a0 = 1'b0;
        chk(wr_count == 0, "R2 no writes during sweep", wr_count, 0);

        // R4 / R5 / R7 / R8: write then read each register of the window
        for (int r = 0; r < 32; r++) begin
            d = 8'((r * 37 + 5) & 255);
            do_write(8'(r), d, ka, kr, kd);
            chk(ka == 1'b1, "R2 write addr ack", int'(ka), 1);
            chk(kr == reg_valid(r), "R8 register ack", int'(kr), int'(reg_valid(r)));
            if (reg_valid(r)) begin
                chk(kd == 1'b1, "R4 data ack", int'(kd), 1);
                model[r] = d;
                exp_wr++;
                chk(reg_addr == 8'(r), "R7 pointer after write", int'(reg_addr), r);
            end
            chk(bank[r] == model[r], "R4 bank contents", int'(bank[r]), int'(model[r]));
            do_read(8'(r), kr, k2, v);
            if (reg_valid(r)) begin
                chk(k2 == 1'b1, "R5 read addr ack", int'(k2), 1);
                chk(v == model[r], "R5 read data", int'(v), int'(model[r]));
            end else begin
                chk(kr == 1'b0, "R8 reserved read", int'(kr), 0);
            end
        end
        // R8: out-of-window register bytes
        for (int k = 0; k < 3; k++) begin
            logic [7:0] rb;
            rb = (k == 0) ? 8'h20 : ((k == 1) ? 8'h80 : 8'hFF);
            do_write(rb, 8'h3C, ka, kr, kd);
            chk(kr == 1'b0, "R8 out of range nack", int'(kr), 0);
            chk(bank[rb] == model[rb], "R8 out of range unchanged", int'(bank[rb]), int'(model[rb]));
        end
        chk(wr_count == exp_wr, "R4 one strobe per write", wr_count, exp_wr);

        // R6: send byte loads the pointer, receive byte rereads it
        wr_before = wr_count;
        do_send(8'h07, kr);
        chk(kr == 1'b1, "R6 send byte ack", int'(kr), 1);
        chk(wr_count == wr_before, "R6 send byte no write", wr_count, wr_before);
        do_recv(ka, v);
        chk(v == model[7], "R6 receive byte", int'(v), int'(model[7]));
        do_recv(ka, v);
        chk(v == model[7], "R6 receive byte repeat", int'(v), int'(model[7]));
        // R8: rejected register keeps the pointer
        do_send(8'h0A, kr);
        chk(kr == 1'b0, "R8 reserved send nack", int'(kr), 0);
        do_recv(ka, v);
        chk(v == model[7], "R8 pointer kept", int'(v), int'(model[7]));
        // R7: write byte moves pointer for receive byte
        do_write(8'h14, 8'hC3, ka, kr, kd);
        model[20] = 8'hC3;
        exp_wr++;
        do_recv(ka, v);
        chk(v == 8'hC3, "R7 receive after write", int'(v), 8'hC3);

        // R9: aborted writes
        wr_before = wr_count;
        bus_start(); put_byte(dev_byte(1'b0), ka); put_byte(8'h03, kr);
        put_byte(8'h11, kd); bus_rstart(); bus_stop();
        chk(bank[3] == model[3], "R9 start before stop", int'(bank[3]), int'(model[3]));
        bus_start(); put_byte(dev_byte(1'b0), ka); put_byte(8'h04, kr);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); bus_stop();
        chk(bank[4] == model[4], "R9 stop mid byte", int'(bank[4]), int'(model[4]));
        bus_start(); put_byte(dev_byte(1'b0), ka); put_byte(8'h05, kr);
        put_byte(8'h22, kd); put_byte(8'h33, k2); bus_stop();
        chk(k2 == 1'b0, "R9 extra byte nack", int'(k2), 0);
        chk(bank[5] == model[5], "R9 extra byte no write", int'(bank[5]), int'(model[5]));
        chk(wr_count == wr_before, "R9 no strobes", wr_count, wr_before);

        // R10: write direction after repeated START
        bus_start(); put_byte(dev_byte(1'b0), ka); put_byte(8'h06, kr);
        bus_rstart(); put_byte(dev_byte(1'b0), k2); bus_stop();
        chk(k2 == 1'b0, "R10 write after restart", int'(k2), 0);

        // R11: silence after rejection
        bus_start(); put_byte(8'h5C, ka); put_byte(dev_byte(1'b0), k2); bus_stop();
        chk(ka == 1'b0, "R11 bad address nack", int'(ka), 0);
        chk(k2 == 1'b0, "R11 silent afterwards", int'(k2), 0);
        bus_start(); put_byte(dev_byte(1'b0), ka); put_byte(8'h0F, kr);
        put_byte(8'h44, kd); bus_stop();
        chk(kd == 1'b0, "R11 silent after bad register", int'(kd), 0);

        chk(wr_count == exp_wr, "R4 total strobes", wr_count, exp_wr);
        chk(hi_changes == 0, "R12 sda_oe stable while SCL high", hi_changes, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule